// File: doc/BRIEF.md
# ECC Error Report Aggregator

This block sits beside a BCH decoder in a NAND page-read path and condenses the per-packet decode results of one page into a single 32-bit report word. A page is opened with a one-cycle start pulse. The decoder then presents one result per packet: a strobe, a corrected-bit count and a success flag. The first packet of the page keeps a record of its own. Every later packet folds into one shared record. That shared record keeps the largest count seen, not the sum, and it keeps a success flag that is cleared by any failure.

A page-empty indication from the read path is latched into a separate status bit. Software must treat the report as meaningless whenever that bit is set, because erased pages are not screened for bitflips. Once the configured number of packets has been seen, a done flag rises and the report freezes until the next start pulse. The number of packets per page is taken from a step-count input.

Top module: `ecc_report_agg`

## Requirements
- R1: After reset and after every start pulse, the report reads 32'h0000_8080: both counts are 0 and both success bits are 1. At the same time done is 0 and page_empty is 0.
- R2: The first accepted packet of a page writes its count into report bits 5:0 and its success flag into bit 7, where 1 means a successful decode.
- R3: Report bits 13:8 hold the maximum count over all accepted packets after the first. The value stays 0 when no such packet exists.
- R4: Report bit 15 is the AND of the success flags of all accepted packets after the first. Once it is cleared, it stays 0 until the next start pulse.
- R5: Done rises in the cycle after the strobe of packet number step_count, counting from 1, and holds until the next start pulse. A step_count of 0 behaves as 1.
- R6: A strobe that arrives while done is high is ignored. The report and page_empty stay unchanged while done holds.
- R7: A strobe in the same cycle as a start pulse is discarded. The page opens empty, exactly as in R1.
- R8: page_empty becomes 1 the cycle after page_empty_in is sampled high while the page is open (done low, no start pulse). It then stays 1 until the next start pulse.
- R9: Report bits 31:16, bit 6 and bit 14 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| page_start | input | 1 | One-cycle pulse that opens a new page |
| page_empty_in | input | 1 | Erased-page indication from the read path |
| step_count | input | STEP_W | Number of packets per page |
| pkt_valid | input | 1 | Strobe that marks one packet result |
| pkt_errs | input | ERR_W | Corrected-bit count of the packet |
| pkt_ok | input | 1 | Packet decoded successfully |
| report | output | 32 | Packed error report word |
| page_empty | output | 1 | Sticky erased-page status |
| done | output | 1 | All configured packets have been received |

## Verification
Two events can fall in the same cycle and need a defined winner. The first is a start pulse together with a packet strobe. The second is the last packet's strobe together with a page-empty indication. The bench drives a strobe on the same edge as a new start and expects the pristine report of R1, which shows that the packet was discarded. It also raises page_empty_in alongside the final strobe and expects both done and page_empty to be set on the following cycle. The remaining results come from sweeps over step counts 0 to 6. Each sweep uses arithmetic count and failure patterns, and the bench computes the expected running maximum and AND for every packet.

// File: rtl/ecc_rpt_pkg.sv
package ecc_rpt_pkg;
  localparam int RPT_W  = 32;
  localparam int BYTE_W = 8;
  localparam int ERR_W  = 6;

  typedef struct packed {
    logic             ok;
    logic [ERR_W-1:0] cnt;
  } rec_t;

  function automatic logic [BYTE_W-1:0] pack_rec(rec_t r);
    return {r.ok, {(BYTE_W-ERR_W-1){1'b0}}, r.cnt};
  endfunction
endpackage

// File: rtl/ecc_rpt_rstsync.sv
module ecc_rpt_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ecc_rpt_seq.sv
module ecc_rpt_seq #(
  parameter int STEP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              valid,
  input  logic [STEP_W-1:0] step_count,
  output logic              upd_first,
  output logic              upd_rest,
  output logic              open,
  output logic              done
);
  logic [STEP_W-1:0] idx_q, idx_d;
  logic              done_q, done_d;
  logic              accept, last;

  always_comb begin
    accept    = valid && !start && !done_q;
    last      = ({1'b0, idx_q} + 1'b1) >= {1'b0, step_count};
    upd_first = accept && (idx_q == '0);
    upd_rest  = accept && (idx_q != '0);
    idx_d     = idx_q;
    done_d    = done_q;
    if (start) begin
      idx_d  = '0;
      done_d = 1'b0;
    end else if (accept) begin
      idx_d = idx_q + 1'b1;
      if (last) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
  assign open = !done_q && !start;

  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !start |=> done_q);
  // R5
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(valid) && !$past(start));
  // R7
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done_q && idx_q == '0);
endmodule

// File: rtl/ecc_rpt_record.sv
module ecc_rpt_record
  import ecc_rpt_pkg::*;
#(
  parameter bit MERGE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd,
  input  logic [ERR_W-1:0] errs,
  input  logic             ok_in,
  output rec_t             rec
);
  rec_t rec_q, rec_d, rec_new;

  generate
    if (MERGE) begin : g_merge
      always_comb begin
        rec_new.cnt = (errs > rec_q.cnt) ? errs : rec_q.cnt;
        rec_new.ok  = rec_q.ok & ok_in;
      end
    end else begin : g_single
      always_comb begin
        rec_new.cnt = errs;
        rec_new.ok  = ok_in;
      end
    end
  endgenerate

  always_comb begin
    rec_d = rec_q;
    if (clr)      rec_d = '{ok: 1'b1, cnt: '0};
    else if (upd) rec_d = rec_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rec_q <= '{ok: 1'b1, cnt: '0};
    else        rec_q <= rec_d;
  end

  assign rec = rec_q;

  // R1
  clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> rec_q.cnt == '0 && rec_q.ok);

  generate
    if (MERGE) begin : g_merge_chk
      // R3
      max_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> rec_q.cnt >= $past(rec_q.cnt));
      // R4
      fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr && !rec_q.ok |=> !rec_q.ok);
    end
  endgenerate
endmodule

// File: rtl/ecc_report_agg.sv
module ecc_report_agg
  import ecc_rpt_pkg::*;
#(
  parameter int MAX_STEPS = 16,
  localparam int STEP_W   = $clog2(MAX_STEPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_start,
  input  logic              page_empty_in,
  input  logic [STEP_W-1:0] step_count,
  input  logic              pkt_valid,
  input  logic [ERR_W-1:0]  pkt_errs,
  input  logic              pkt_ok,
  output logic [RPT_W-1:0]  report,
  output logic              page_empty,
  output logic              done
);
  logic rst_n_s;
  logic upd_first, upd_rest, open;
  rec_t rec_first, rec_rest;
  logic empty_q, empty_d;

  ecc_rpt_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  ecc_rpt_seq #(.STEP_W(STEP_W)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .start(page_start), .valid(pkt_valid),
    .step_count(step_count), .upd_first(upd_first), .upd_rest(upd_rest),
    .open(open), .done(done)
  );

  ecc_rpt_record #(.MERGE(1'b0)) u_first (
    .clk(clk), .rst_n(rst_n_s), .clr(page_start), .upd(upd_first),
    .errs(pkt_errs), .ok_in(pkt_ok), .rec(rec_first)
  );

  ecc_rpt_record #(.MERGE(1'b1)) u_rest (
    .clk(clk), .rst_n(rst_n_s), .clr(page_start), .upd(upd_rest),
    .errs(pkt_errs), .ok_in(pkt_ok), .rec(rec_rest)
  );

  always_comb begin
    empty_d = empty_q;
    if (page_start)                  empty_d = 1'b0;
    else if (open && page_empty_in)  empty_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) empty_q <= 1'b0;
    else          empty_q <= empty_d;
  end

  assign page_empty = empty_q;
  assign report     = {{(RPT_W-2*BYTE_W){1'b0}}, pack_rec(rec_rest), pack_rec(rec_first)};

  // R6
  report_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    done && !page_start |=> $stable(report) && $stable(page_empty));
  // R8
  empty_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    page_empty && !page_start |=> page_empty);
  // R2
  first_load_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    upd_first |=> report[ERR_W-1:0] == $past(pkt_errs) && report[7] == $past(pkt_ok));
endmodule

// File: tb/sim_ecc_report_agg.sv
module sim_ecc_report_agg;
  localparam int STEP_W = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              page_start, page_empty_in, pkt_valid, pkt_ok;
  logic [STEP_W-1:0] step_count;
  logic [5:0]        pkt_errs;
  logic [31:0]       report;
  logic              page_empty, done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ecc_report_agg #(.MAX_STEPS(16)) u0 (
    .clk(clk), .rst_n(rst_n), .page_start(page_start),
    .page_empty_in(page_empty_in), .step_count(step_count),
    .pkt_valid(pkt_valid), .pkt_errs(pkt_errs), .pkt_ok(pkt_ok),
    .report(report), .page_empty(page_empty), .done(done)
  );

  task automatic chk(string req, logic [33:0] act, logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic start_page(int n);
    step_count = STEP_W'(n);
    page_start = 1'b1;
    tick();
    page_start = 1'b0;
  endtask

  task automatic send(logic [5:0] e, logic ok, logic emp);
    pkt_valid = 1'b1; pkt_errs = e; pkt_ok = ok; page_empty_in = emp;
    tick();
    pkt_valid = 1'b0; page_empty_in = 1'b0;
  endtask

  function automatic logic [31:0] mk(logic [5:0] c0, logic o0, logic [5:0] c1, logic o1);
    return {16'h0, o1, 1'b0, c1, o0, 1'b0, c0};
  endfunction

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0]  c0, c1;
    logic        o0, o1;
    logic [31:0] snap;
    rst_n = 1'b0; page_start = 1'b0; page_empty_in = 1'b0; pkt_valid = 1'b0;
    pkt_ok = 1'b1; pkt_errs = '0; step_count = STEP_W'(1);
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    // R1 reset state, R9 unused bits
    chk("R1", {done, page_empty, report}, {2'b00, 32'h0000_8080});

    for (int seed = 0; seed < 6; seed++) begin
      for (int n = 0; n <= 6; n++) begin
        int eff;
        eff = (n == 0) ? 1 : n;
        start_page(n);
        chk("R1", {done, page_empty, report}, {2'b00, 32'h0000_8080});
        c0 = '0; o0 = 1'b1; c1 = '0; o1 = 1'b1;
        for (int i = 0; i < eff; i++) begin
          logic [5:0] e;
          logic       ok;
          e  = 6'((seed * 23 + i * 37 + n * 11) % 64);
          ok = ((seed + i * 3 + n) % 5) != 0;
          send(e, ok, 1'b0);
          if (i == 0) begin c0 = e; o0 = ok; end
          else begin
            if (e > c1) c1 = e;
            o1 = o1 & ok;
          end
          // R2 first byte, R3 running max, R4 sticky AND, R9 zero bits
          chk(i == 0 ? "R2" : "R3_R4", {2'b00, report}, {2'b00, mk(c0, o0, c1, o1)});
          // R5 done exactly after packet number step_count (0 acts as 1)
          chk("R5", {33'h0, done}, {33'h0, (i == eff - 1)});
        end
        // R6 extra strobes ignored while done
        snap = report;
        send(6'h3f, 1'b0, 1'b1);
        send(6'h3e, 1'b0, 1'b0);
        chk("R6", {done, page_empty, report}, {2'b10, snap});
      end
    end

    // R7 strobe on the same edge as start is discarded
    step_count = STEP_W'(3);
    page_start = 1'b1; pkt_valid = 1'b1; pkt_errs = 6'd9; pkt_ok = 1'b0;
    tick();
    page_start = 1'b0; pkt_valid = 1'b0;
    chk("R7", {done, page_empty, report}, {2'b00, 32'h0000_8080});
    send(6'd4, 1'b1, 1'b0);
    chk("R7", {2'b00, report}, {2'b00, mk(6'd4, 1'b1, 6'd0, 1'b1)});

    // R8 page-empty sampled with the last strobe
    send(6'd2, 1'b1, 1'b0);
    chk("R8", {33'h0, page_empty}, 34'h0);
    send(6'd7, 1'b1, 1'b1);
    chk("R8", {done, page_empty, report}, {2'b11, mk(6'd4, 1'b1, 6'd7, 1'b1)});
    start_page(2);
    chk("R8", {33'h0, page_empty}, 34'h0);

    // R8 empty alone mid-page, R4 failure sticky through later passes
    page_empty_in = 1'b1; tick(); page_empty_in = 1'b0;
    chk("R8", {33'h0, page_empty}, {33'h0, 1'b1});
    send(6'd63, 1'b1, 1'b0);
    send(6'd1, 1'b0, 1'b0);
    chk("R4", {done, page_empty, report}, {2'b11, mk(6'd63, 1'b1, 6'd1, 1'b0)});

    start_page(4);
    send(6'd0, 1'b1, 1'b0);
    send(6'd5, 1'b0, 1'b0);
    send(6'd3, 1'b1, 1'b0);
    send(6'd5, 1'b1, 1'b0);
    chk("R4", {done, page_empty, report}, {2'b10, mk(6'd0, 1'b1, 6'd5, 1'b0)});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule